// File: doc/BRIEF.md
# Many-Valued JK Storage Cell

This block is a clocked storage element that keeps a graded truth level rather than a single bit. A level is an unsigned integer from 0 up to a full-scale value `FS`, which is a parameter with a default of 6. On each clock edge where enable is high, the cell computes its next level from two control levels, J and K, and from its present level Q.

The next-level logic has three operators. Fuzzy AND is the minimum of two levels, fuzzy OR is the maximum, and the complement of a level x is `FS - x`. A two-bit mode input selects one of three characteristic equations: reset-type, set-type or min-max.

Some combinations of J and K make the stored level swing back and forth between two values on successive edges. A sticky flag reports this alternation, so that logic further along the chip can tell that the cell is not settling.

Top module: `fuzzy_jk_cell`

## Requirements
- R1: Levels are `W = $clog2(FS+1)` bits wide. A J or K value above FS is treated as FS.
- R2: When `rst` is high at a clock edge, `q_out` becomes 0 and `osc_out` becomes 0.
- R3: When `en` is low at a clock edge (and `rst` is low), `q_out` and `osc_out` keep their values.
- R4: Mode 0 (reset-type): the next level is `max(min(J, FS-Q), min(FS-K, Q))`.
- R5: Mode 1 (set-type): the next level is `min(max(J, Q), max(FS-K, FS-Q))`.
- R6: Mode 2 and mode 3 (min-max): the next level is the minimum of `max(J, FS-K)`, `max(J, Q)` and `max(FS-K, FS-Q)`.
- R7: With FS = 6, mode 0 and J = K = 4 held, Q goes 0, 4, 2, 4 from reset. Starting from Q = 2, it goes 4, 2, 4.
- R8: `osc_out` is set at an enabled edge where all three of these hold:
  - the new level equals the level from two updates earlier;
  - the new level differs from the level one update earlier;
  - J, K and mode are unchanged since the previous enabled edge.
- R9: `osc_out` stays set while J, K and mode stay unchanged. It clears at the first enabled edge where any of them differs from its value at the previous enabled edge.
- R10: `q_out` never exceeds FS.
- R11: In min-max mode, J = FS with K = 0 drives Q to FS, and J = 0 with K = FS drives Q to 0, whatever the present level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable |
| mode | input | 2 | 0 reset-type, 1 set-type, 2 or 3 min-max |
| j_in | input | W | J level |
| k_in | input | W | K level |
| q_out | output | W | Stored level (registered) |
| osc_out | output | 1 | Alternation flag (registered) |

## Verification
Only one register stands between the inputs and `q_out`, so a wrong next-level term shows at the port on the edge right after the inputs that expose it. Every mode, every J and K code (including the codes above FS) and every starting level is therefore checked one edge after it is applied. A wrong history or change-tracking register cannot be seen on the level itself. It shows only through `osc_out`, at the third update of an alternating run or at the first edge after the inputs change, so those edges are sampled explicitly.

// File: rtl/fjk_pkg.sv
package fjk_pkg;
  typedef enum logic [1:0] {
    FJK_RESET_T  = 2'd0,
    FJK_SET_T    = 2'd1,
    FJK_MINMAX   = 2'd2,
    FJK_MINMAX_B = 2'd3
  } fjk_mode_e;
endpackage

// File: rtl/fjk_clamp.sv
module fjk_clamp #(
  parameter int FS = 6,
  parameter int W  = $clog2(FS + 1)
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  localparam logic [W-1:0] FSV = W'(FS);

  // Codes above full scale saturate to full scale.
  always_comb lvl_o = (raw_i > FSV) ? FSV : raw_i;
endmodule

// File: rtl/fjk_next.sv
module fjk_next
  import fjk_pkg::*;
#(
  parameter int FS = 6,
  parameter int W  = $clog2(FS + 1)
) (
  input  fjk_mode_e    mode_i,
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] FSV = W'(FS);

  function automatic logic [W-1:0] lmin(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] lmax(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [W-1:0] nk, nq;
  logic [W-1:0] rst_form, set_form, mm_form;

  always_comb begin
    // Complement of a level: full scale minus the level.
    nk = FSV - k_i;
    nq = FSV - q_i;
    rst_form = lmax(lmin(j_i, nq), lmin(nk, q_i));
    set_form = lmin(lmax(j_i, q_i), lmax(nk, nq));
    mm_form  = lmin(lmin(lmax(j_i, nk), lmax(j_i, q_i)), lmax(nk, nq));
    unique case (mode_i)
      FJK_RESET_T: nxt_o = rst_form;
      FJK_SET_T:   nxt_o = set_form;
      default:     nxt_o = mm_form;
    endcase
  end
endmodule

// File: rtl/fjk_osc.sv
module fjk_osc #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         chg_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] nxt_i,
  output logic         osc_o
);
  logic [W-1:0] prev_q;
  logic         prev_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
      osc_o    <= 1'b0;
    end else if (en) begin
      prev_q   <= q_i;
      prev_vld <= 1'b1;
      if (chg_i)
        osc_o <= 1'b0;
      else if (prev_vld && (nxt_i == prev_q) && (nxt_i != q_i))
        osc_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fuzzy_jk_cell.sv
module fuzzy_jk_cell
  import fjk_pkg::*;
#(
  parameter int FS = 6,
  parameter int W  = $clog2(FS + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] j_in,
  input  logic [W-1:0] k_in,
  output logic [W-1:0] q_out,
  output logic         osc_out
);
  logic [W-1:0] j_lvl, k_lvl, nxt;
  logic [W-1:0] last_j, last_k;
  logic [1:0]   last_m;
  logic         chg;

  fjk_clamp #(.FS(FS), .W(W)) clamp_j_i (.raw_i(j_in), .lvl_o(j_lvl));
  fjk_clamp #(.FS(FS), .W(W)) clamp_k_i (.raw_i(k_in), .lvl_o(k_lvl));

  fjk_next #(.FS(FS), .W(W)) next_i (
    .mode_i (fjk_mode_e'(mode)),
    .j_i    (j_lvl),
    .k_i    (k_lvl),
    .q_i    (q_out),
    .nxt_o  (nxt)
  );

  // Inputs differ from those used at the previous enabled edge.
  always_comb chg = (j_lvl != last_j) || (k_lvl != last_k) || (mode != last_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out  <= '0;
      last_j <= '0;
      last_k <= '0;
      last_m <= '0;
    end else if (en) begin
      q_out  <= nxt;
      last_j <= j_lvl;
      last_k <= k_lvl;
      last_m <= mode;
    end
  end

  fjk_osc #(.W(W)) osc_i (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .chg_i (chg),
    .q_i   (q_out),
    .nxt_i (nxt),
    .osc_o (osc_out)
  );
endmodule

// File: rtl/fjk_checker.sv
module fjk_checker #(
  parameter int FS = 6,
  parameter int W  = $clog2(FS + 1)
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [1:0]   mode,
  input logic [W-1:0] j_in,
  input logic [W-1:0] k_in,
  input logic [W-1:0] q_out,
  input logic         osc_out
);
  localparam logic [W-1:0] FSV = W'(FS);

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (q_out == '0) && !osc_out);  // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q_out) && $stable(osc_out));  // R3

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    q_out <= FSV);  // R10

  AST_MM_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && mode[1] && j_in >= FSV && k_in == '0) |=> q_out == FSV);  // R11

  AST_MM_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (en && mode[1] && j_in == '0 && k_in >= FSV) |=> q_out == '0);  // R11
endmodule

bind fuzzy_jk_cell fjk_checker #(.FS(FS), .W(W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .mode(mode), .j_in(j_in),
  .k_in(k_in), .q_out(q_out), .osc_out(osc_out)
);

// File: tb/fuzzy_jk_cell_tb_top.sv
module fuzzy_jk_cell_tb_top;
  localparam int PERIOD = 10;
  localparam int FS = 6;
  localparam int W  = $clog2(FS + 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] j_in = '0;
  logic [W-1:0] k_in = '0;
  logic [W-1:0] q_out;
  logic         osc_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  fuzzy_jk_cell #(.FS(FS), .W(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .j_in(j_in),
    .k_in(k_in), .q_out(q_out), .osc_out(osc_out)
  );

  function automatic int clampv(int v);
    return (v > FS) ? FS : v;
  endfunction

  function automatic int mn(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int model(int m, int jr, int kr, int q);
    int j = clampv(jr);
    int k = clampv(kr);
    if (m == 0) return mx(mn(j, FS - q), mn(FS - k, q));
    if (m == 1) return mn(mx(j, q), mx(FS - k, FS - q));
    return mn(mn(mx(j, FS - k), mx(j, q)), mx(FS - k, FS - q));
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(int v);
    en = 1'b1;
    mode = 2'd2;
    j_in = W'(v);
    k_in = W'(FS - v);
    tick();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    chk("R2 reset level", int'(q_out), 0);
    chk("R2 reset flag", int'(osc_out), 0);

    // R7 / R8 alternation from zero with reset-type mode
    en = 1'b1; mode = 2'd0; j_in = 3'd4; k_in = 3'd4;
    tick(); chk("R7 step1", int'(q_out), 4); chk("R8 no flag yet", int'(osc_out), 0);
    tick(); chk("R7 step2", int'(q_out), 2); chk("R8 no flag yet", int'(osc_out), 0);
    tick(); chk("R7 step3", int'(q_out), 4); chk("R8 flag set", int'(osc_out), 1);
    en = 1'b0;
    tick(); chk("R3 hold level", int'(q_out), 4); chk("R3 hold flag", int'(osc_out), 1);
    en = 1'b1;
    tick(); chk("R9 sticky level", int'(q_out), 2); chk("R9 sticky flag", int'(osc_out), 1);
    k_in = 3'd5;
    tick(); chk("R9 change level", int'(q_out), 4); chk("R9 clear on change", int'(osc_out), 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R2 mid-run reset level", int'(q_out), 0);
    chk("R2 mid-run reset flag", int'(osc_out), 0);

    // R7 alternation from two
    load(2);
    chk("R7 load two", int'(q_out), 2);
    mode = 2'd0; j_in = 3'd4; k_in = 3'd4;
    tick(); chk("R7 from2 step1", int'(q_out), 4);
    tick(); chk("R7 from2 step2", int'(q_out), 2);
    tick(); chk("R7 from2 step3", int'(q_out), 4);

    // R11 min-max forcing
    load(3);
    mode = 2'd2; j_in = W'(FS); k_in = 3'd0;
    tick(); chk("R11 force high", int'(q_out), FS);
    j_in = 3'd0; k_in = W'(FS);
    tick(); chk("R11 force low", int'(q_out), 0);

    // Exhaustive sweep: R1 R4 R5 R6 R10
    for (int m = 0; m < 4; m++) begin
      for (int j = 0; j < (1 << W); j++) begin
        for (int k = 0; k < (1 << W); k++) begin
          for (int q = 0; q <= FS; q++) begin
            int exp;
            string req;
            load(q);
            mode = 2'(m); j_in = W'(j); k_in = W'(k);
            tick();
            exp = model(m, j, k, q);
            if (j > FS || k > FS) req = "R1 clamp";
            else if (m == 0) req = "R4 reset-type";
            else if (m == 1) req = "R5 set-type";
            else req = "R6 min-max";
            chk(req, int'(q_out), exp);
            if (int'(q_out) > FS) chk("R10 range", int'(q_out), FS);
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule